// File: doc/BRIEF.md
# Stack Machine Execution Datapath

This block is the execute stage of a small byte-wide stack processor. It keeps the top two data-stack entries in the registers T and N, with deeper entries in a circular stack memory. The top of the return stack is held in the register R, with deeper return entries in a second circular memory. On every clock edge it applies one decoded operation, together with an optional literal, and finishes it in that same cycle. The operations cover arithmetic, carry extraction, bitwise logic, shifts and rotates, flag tests, and data- and return-stack shuffles.

Fetch, branching, program counting and I/O are supplied by the surrounding processor. This block only holds the stack state and transforms it. Every operand is the value of T, N or R at the start of the cycle. The fill level of each stack memory and sticky overflow and underflow flags are available at the ports. Neither condition stops execution.

Top module: `stk_datapath`

## Requirements
- R1: A clock edge with `rst_n` low clears T, N, R, both fill levels, all four flags and every stack memory entry to zero.
- R2: Binary ops replace T with N op T, modulo 256, and pop the next memory entry into N, lowering the data fill by one. The opcodes are add 1 (N+T), subtract 2 (N−T), and 3, or 4 and xor 5.
- R3: Op 6 pushes the carry out of N+T and op 7 pushes the borrow of N−T (1 when N<T). The bit is pushed as 0x01 or 0x00. The old T becomes N and the old N goes into the memory.
- R4: Op 8 sets T to T+1 and op 9 sets T to T−1, both modulo 256, leaving N and the depth unchanged.
- R5: The shift and rotate ops change T only:
  - 10: left, fill 0
  - 11: left, fill 1
  - 12: right, fill 0
  - 13: right, fill 1
  - 14: right, keep bit 7
  - 15: rotate right, bit 0 into bit 7
  - 16: rotate left, bit 7 into bit 0
- R6: Each flag op replaces T with 0xFF when its test is true and 0x00 when false. Op 17 tests T==0, op 18 tests T!=0, op 19 tests T==0xFF and op 20 tests T!=0xFF.
- R7: The data-stack shuffles work as follows:
  - drop (21): T←N and pop into N
  - dup (22): push, with N←T
  - nip (23): pop into N, T kept
  - over (24): push, with T←N and N←T
  - swap (26): exchange T and N, depth unchanged
- R8: Op 25 pushes the literal: T←literal, N←T, and the old N goes into the memory. The literal has no effect on any other op.
- R9: Return-stack ops:
  - 27: moves T to R, pushes the old R into the return memory, and pops the data stack as drop does.
  - 28: pushes R onto the data stack and pops the return memory into R.
  - 29: pushes R onto the data stack and leaves the return stack unchanged.
- R10: Op 0 and every code from 30 to 63 leave all state and outputs unchanged.
- R11: A push to a full memory sets that stack's sticky overflow flag. The fill level stays at the depth, and the write pointer wraps and overwrites the oldest entry.
- R12: A pop from an empty memory sets that stack's sticky underflow flag. The fill level stays 0, the pointer wraps downward, and the value read is the entry at the wrapped position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op | input | 6 | Operation code for this cycle |
| lit | input | W | Literal, used only by the push-literal op |
| tos | output | W | Register T |
| nos | output | W | Register N |
| rtop | output | W | Register R |
| ds_fill | output | clog2(DS_DEPTH)+1 | Entries held in the data stack memory |
| rs_fill | output | clog2(RS_DEPTH)+1 | Entries held in the return stack memory |
| ds_ovf | output | 1 | Sticky data-stack overflow |
| ds_unf | output | 1 | Sticky data-stack underflow |
| rs_ovf | output | 1 | Sticky return-stack overflow |
| rs_unf | output | 1 | Sticky return-stack underflow |

## Verification
The bench builds the block with a data memory depth of 8 and a return memory depth of 4, rather than the default 32. With these depths a few pushes or pops take either stack past full or empty. Random streams of opcodes therefore wrap both circular pointers many times, and the overflow and underflow paths, including reads of wrapped entries, are exercised often. The random opcode range also covers the unused codes 30 and 31.

// File: rtl/stk_pkg.sv
// Shared opcode encoding and control types for the stack datapath.
package stk_pkg;

    // Opcode codes; values are part of the block's interface.
    typedef enum logic [5:0] {
        OP_NOP    = 6'd0,
        OP_ADD    = 6'd1,
        OP_SUB    = 6'd2,
        OP_AND    = 6'd3,
        OP_OR     = 6'd4,
        OP_XOR    = 6'd5,
        OP_ADDC   = 6'd6,
        OP_SUBC   = 6'd7,
        OP_INC    = 6'd8,
        OP_DEC    = 6'd9,
        OP_SHL0   = 6'd10,
        OP_SHL1   = 6'd11,
        OP_SHR0   = 6'd12,
        OP_SHR1   = 6'd13,
        OP_SHRS   = 6'd14,
        OP_ROR    = 6'd15,
        OP_ROL    = 6'd16,
        OP_ZEQ    = 6'd17,
        OP_ZNE    = 6'd18,
        OP_MEQ    = 6'd19,
        OP_MNE    = 6'd20,
        OP_DROP   = 6'd21,
        OP_DUP    = 6'd22,
        OP_NIP    = 6'd23,
        OP_OVER   = 6'd24,
        OP_LIT    = 6'd25,
        OP_SWAP   = 6'd26,
        OP_TOR    = 6'd27,
        OP_RFROM  = 6'd28,
        OP_RFETCH = 6'd29
    } stk_op_e;

    // Source of the next T value.
    typedef enum logic [2:0] {
        T_KEEP, T_ALU, T_FROM_N, T_FROM_LIT, T_FROM_R
    } t_sel_e;

    // Source of the next N value.
    typedef enum logic [1:0] {
        N_KEEP, N_FROM_T, N_FROM_MEM
    } n_sel_e;

    // Source of the next R value.
    typedef enum logic [1:0] {
        R_KEEP, R_FROM_T, R_FROM_MEM
    } r_sel_e;

    // Decoded control word for one cycle.
    typedef struct packed {
        t_sel_e t_sel;
        n_sel_e n_sel;
        r_sel_e r_sel;
        logic   ds_push;
        logic   ds_pop;
        logic   rs_push;
        logic   rs_pop;
    } stk_ctrl_t;

endpackage

// File: rtl/stk_alu.sv
// stk_alu: combinational value unit. From the start-of-cycle T and N it
// computes the new T for arithmetic, carry, logic, shift, rotate and flag
// operations. Assumes W >= 2. Codes that are not value operations give zero;
// the controller never selects the result for them.
module stk_alu
    import stk_pkg::*;
#(
    parameter int W = 8
) (
    input  stk_op_e        op,
    input  logic [W-1:0]   t,
    input  logic [W-1:0]   n,
    output logic [W-1:0]   res
);
    localparam logic [W-1:0] ALL1 = {W{1'b1}};
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W:0] sum_x;
    logic       borrow;

    // Extended sum for the carry op; borrow is an unsigned compare.
    always_comb begin
        sum_x  = {1'b0, n} + {1'b0, t};
        borrow = (n < t);
    end

    // Result selection by opcode.
    always_comb begin
        unique case (op)
            OP_ADD:  res = n + t;
            OP_SUB:  res = n - t;
            OP_AND:  res = n & t;
            OP_OR:   res = n | t;
            OP_XOR:  res = n ^ t;
            OP_ADDC: res = sum_x[W] ? ONE : '0;
            OP_SUBC: res = borrow ? ONE : '0;
            OP_INC:  res = t + ONE;
            OP_DEC:  res = t - ONE;
            OP_SHL0: res = {t[W-2:0], 1'b0};
            OP_SHL1: res = {t[W-2:0], 1'b1};
            OP_SHR0: res = {1'b0, t[W-1:1]};
            OP_SHR1: res = {1'b1, t[W-1:1]};
            OP_SHRS: res = {t[W-1], t[W-1:1]};
            OP_ROR:  res = {t[0], t[W-1:1]};
            OP_ROL:  res = {t[W-2:0], t[W-1]};
            OP_ZEQ:  res = (t == '0)   ? ALL1 : '0;
            OP_ZNE:  res = (t != '0)   ? ALL1 : '0;
            OP_MEQ:  res = (t == ALL1) ? ALL1 : '0;
            OP_MNE:  res = (t != ALL1) ? ALL1 : '0;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/stk_ctrl.sv
// stk_ctrl: maps an opcode onto register-source selects and stack push/pop
// strobes. Purely combinational. Assumes at most one push or one pop per
// stack per cycle; unknown codes decode to "hold everything".
module stk_ctrl
    import stk_pkg::*;
(
    input  stk_op_e    op,
    output stk_ctrl_t  ctl
);
    // Decode table.
    always_comb begin
        ctl = '{t_sel: T_KEEP, n_sel: N_KEEP, r_sel: R_KEEP,
                ds_push: 1'b0, ds_pop: 1'b0, rs_push: 1'b0, rs_pop: 1'b0};
        unique case (op)
            OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: begin
                ctl.t_sel  = T_ALU;
                ctl.n_sel  = N_FROM_MEM;
                ctl.ds_pop = 1'b1;
            end
            OP_ADDC, OP_SUBC: begin
                ctl.t_sel   = T_ALU;
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
            end
            OP_INC, OP_DEC, OP_SHL0, OP_SHL1, OP_SHR0, OP_SHR1, OP_SHRS,
            OP_ROR, OP_ROL, OP_ZEQ, OP_ZNE, OP_MEQ, OP_MNE: begin
                ctl.t_sel = T_ALU;
            end
            OP_DROP: begin
                ctl.t_sel  = T_FROM_N;
                ctl.n_sel  = N_FROM_MEM;
                ctl.ds_pop = 1'b1;
            end
            OP_DUP: begin
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
            end
            OP_NIP: begin
                ctl.n_sel  = N_FROM_MEM;
                ctl.ds_pop = 1'b1;
            end
            OP_OVER: begin
                ctl.t_sel   = T_FROM_N;
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
            end
            OP_LIT: begin
                ctl.t_sel   = T_FROM_LIT;
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
            end
            OP_SWAP: begin
                ctl.t_sel = T_FROM_N;
                ctl.n_sel = N_FROM_T;
            end
            OP_TOR: begin
                ctl.t_sel   = T_FROM_N;
                ctl.n_sel   = N_FROM_MEM;
                ctl.ds_pop  = 1'b1;
                ctl.r_sel   = R_FROM_T;
                ctl.rs_push = 1'b1;
            end
            OP_RFROM: begin
                ctl.t_sel   = T_FROM_R;
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
                ctl.r_sel   = R_FROM_MEM;
                ctl.rs_pop  = 1'b1;
            end
            OP_RFETCH: begin
                ctl.t_sel   = T_FROM_R;
                ctl.n_sel   = N_FROM_T;
                ctl.ds_push = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/stk_lifo.sv
// stk_lifo: circular stack memory below a register-held top entry.
// ptr names the next free slot and the top entry sits at ptr-1. fill counts
// the valid entries and saturates at DEPTH and at 0. A push when full or a
// pop when empty still moves ptr (wrapping) and sets a sticky flag.
// Assumes DEPTH is a power of two >= 2 and push/pop are never both high.
module stk_lifo #(
    parameter int DEPTH = 32,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic                       pop,
    input  logic [W-1:0]               din,
    output logic [W-1:0]               dout,
    output logic [$clog2(DEPTH):0]     fill,
    output logic                       ovf,
    output logic                       unf
);
    localparam int AW = $clog2(DEPTH);
    localparam int FW = AW + 1;
    localparam logic [FW-1:0] FULL = FW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] ptr;

    // Top entry read, combinational.
    assign dout = mem[ptr - AW'(1)];

    // Storage: cleared on reset, written at ptr on push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (push) begin
            mem[ptr] <= din;
        end
    end

    // Pointer, saturating fill and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr  <= '0;
            fill <= '0;
            ovf  <= 1'b0;
            unf  <= 1'b0;
        end else if (push) begin
            ptr <= ptr + AW'(1);
            if (fill == FULL) ovf <= 1'b1;
            else              fill <= fill + FW'(1);
        end else if (pop) begin
            ptr <= ptr - AW'(1);
            if (fill == '0) unf <= 1'b1;
            else            fill <= fill - FW'(1);
        end
    end

    // R11
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill == FULL) |=> (ovf && fill == FULL));

    // R12
    unf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && fill == '0) |=> (unf && fill == '0));

    // R11
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R12
    unf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf |=> unf);

    // R8
    fill_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && fill != FULL) |=> (fill == $past(fill) + FW'(1)));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push && !pop) |=> ($stable(fill) && $stable(dout)));

    // R11
    fill_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FULL);
endmodule

// File: rtl/stk_datapath.sv
// stk_datapath: single-cycle execute stage of a byte-wide stack machine.
// T and N are registers over a data stack memory; R is a register over a
// return stack memory. Each edge applies the opcode on `op`, using only the
// start-of-cycle T, N and R. Assumes depths are powers of two >= 2.
module stk_datapath
    import stk_pkg::*;
#(
    parameter int W        = 8,
    parameter int DS_DEPTH = 32,
    parameter int RS_DEPTH = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [5:0]                  op,
    input  logic [W-1:0]                lit,
    output logic [W-1:0]                tos,
    output logic [W-1:0]                nos,
    output logic [W-1:0]                rtop,
    output logic [$clog2(DS_DEPTH):0]   ds_fill,
    output logic [$clog2(RS_DEPTH):0]   rs_fill,
    output logic                        ds_ovf,
    output logic                        ds_unf,
    output logic                        rs_ovf,
    output logic                        rs_unf
);
    stk_op_e      op_e;
    stk_ctrl_t    ctl;
    logic [W-1:0] t_q, n_q, r_q;
    logic [W-1:0] t_d, n_d, r_d;
    logic [W-1:0] alu_res, ds_top, rs_top;

    assign op_e = stk_op_e'(op);

    stk_ctrl u_ctrl (
        .op  (op_e),
        .ctl (ctl)
    );

    stk_alu #(.W(W)) u_alu (
        .op  (op_e),
        .t   (t_q),
        .n   (n_q),
        .res (alu_res)
    );

    stk_lifo #(.DEPTH(DS_DEPTH), .W(W)) u_dstack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ctl.ds_push),
        .pop   (ctl.ds_pop),
        .din   (n_q),
        .dout  (ds_top),
        .fill  (ds_fill),
        .ovf   (ds_ovf),
        .unf   (ds_unf)
    );

    stk_lifo #(.DEPTH(RS_DEPTH), .W(W)) u_rstack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ctl.rs_push),
        .pop   (ctl.rs_pop),
        .din   (r_q),
        .dout  (rs_top),
        .fill  (rs_fill),
        .ovf   (rs_ovf),
        .unf   (rs_unf)
    );

    // Next-state selection for T, N and R.
    always_comb begin
        unique case (ctl.t_sel)
            T_ALU:      t_d = alu_res;
            T_FROM_N:   t_d = n_q;
            T_FROM_LIT: t_d = lit;
            T_FROM_R:   t_d = r_q;
            default:    t_d = t_q;
        endcase
        unique case (ctl.n_sel)
            N_FROM_T:   n_d = t_q;
            N_FROM_MEM: n_d = ds_top;
            default:    n_d = n_q;
        endcase
        unique case (ctl.r_sel)
            R_FROM_T:   r_d = t_q;
            R_FROM_MEM: r_d = rs_top;
            default:    r_d = r_q;
        endcase
    end

    // Stack top registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
            n_q <= '0;
            r_q <= '0;
        end else begin
            t_q <= t_d;
            n_q <= n_d;
            r_q <= r_d;
        end
    end

    assign tos  = t_q;
    assign nos  = n_q;
    assign rtop = r_q;

    // R10
    nop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_NOP) |=> ($stable(tos) && $stable(nos) && $stable(rtop)
                              && $stable(ds_fill) && $stable(rs_fill)));

    // R7
    swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_SWAP) |=> (tos == $past(nos) && nos == $past(tos)
                               && $stable(ds_fill)));

    // R4
    inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_INC) |=> (tos == $past(tos) + W'(1) && $stable(nos)));

    // R8
    lit_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_LIT) |=> (tos == $past(lit) && nos == $past(tos)));

    // R9
    tor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_TOR) |=> (rtop == $past(tos) && tos == $past(nos)));

    // R9
    rfetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_RFETCH) |=> (tos == $past(rtop) && $stable(rtop)
                                 && $stable(rs_fill)));
endmodule

// File: tb/stk_datapath_bench.sv
`timescale 1ns/1ps
// Bench for stk_datapath: directed corners plus seeded random opcodes,
// checked against a bench-side stack model.
module stk_datapath_bench;
    localparam int DSD = 8;
    localparam int RSD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] op = 6'd0;
    logic [7:0] lit = 8'd0;
    logic [7:0] tos, nos, rtop;
    logic [3:0] ds_fill;
    logic [2:0] rs_fill;
    logic       ds_ovf, ds_unf, rs_ovf, rs_unf;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    stk_datapath #(.W(8), .DS_DEPTH(DSD), .RS_DEPTH(RSD)) u_stk_datapath (
        .clk(clk), .rst_n(rst_n), .op(op), .lit(lit),
        .tos(tos), .nos(nos), .rtop(rtop),
        .ds_fill(ds_fill), .rs_fill(rs_fill),
        .ds_ovf(ds_ovf), .ds_unf(ds_unf), .rs_ovf(rs_ovf), .rs_unf(rs_unf)
    );

    // Reference model state
    logic [7:0] mt, mn, mr;
    logic [7:0] dm [DSD];
    logic [7:0] rm [RSD];
    int dptr, dcnt, rptr, rcnt;
    bit dovf, dunf, rovf, runf;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic m_reset();
        mt = 0; mn = 0; mr = 0;
        for (int i = 0; i < DSD; i++) dm[i] = 0;
        for (int i = 0; i < RSD; i++) rm[i] = 0;
        dptr = 0; dcnt = 0; rptr = 0; rcnt = 0;
        dovf = 0; dunf = 0; rovf = 0; runf = 0;
    endtask

    task automatic d_push(logic [7:0] v);
        dm[dptr] = v;
        dptr = (dptr + 1) % DSD;
        if (dcnt == DSD) dovf = 1; else dcnt++;
    endtask

    task automatic d_pop(output logic [7:0] v);
        dptr = (dptr + DSD - 1) % DSD;
        v = dm[dptr];
        if (dcnt == 0) dunf = 1; else dcnt--;
    endtask

    task automatic r_push(logic [7:0] v);
        rm[rptr] = v;
        rptr = (rptr + 1) % RSD;
        if (rcnt == RSD) rovf = 1; else rcnt++;
    endtask

    task automatic r_pop(output logic [7:0] v);
        rptr = (rptr + RSD - 1) % RSD;
        v = rm[rptr];
        if (rcnt == 0) runf = 1; else rcnt--;
    endtask

    // Value results from R2..R6
    function automatic logic [7:0] exp_val(int o, logic [7:0] t, logic [7:0] n);
        case (o)
            1:  return n + t;
            2:  return n - t;
            3:  return n & t;
            4:  return n | t;
            5:  return n ^ t;
            6:  return ((int'(n) + int'(t)) > 255) ? 8'h01 : 8'h00;
            7:  return (n < t) ? 8'h01 : 8'h00;
            8:  return t + 8'd1;
            9:  return t - 8'd1;
            10: return {t[6:0], 1'b0};
            11: return {t[6:0], 1'b1};
            12: return {1'b0, t[7:1]};
            13: return {1'b1, t[7:1]};
            14: return {t[7], t[7:1]};
            15: return {t[0], t[7:1]};
            16: return {t[6:0], t[7]};
            17: return (t == 8'h00) ? 8'hFF : 8'h00;
            18: return (t != 8'h00) ? 8'hFF : 8'h00;
            19: return (t == 8'hFF) ? 8'hFF : 8'h00;
            20: return (t != 8'hFF) ? 8'hFF : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string req_of(int o);
        if (o >= 1 && o <= 5)   return "R2";
        if (o == 6 || o == 7)   return "R3";
        if (o == 8 || o == 9)   return "R4";
        if (o >= 10 && o <= 16) return "R5";
        if (o >= 17 && o <= 20) return "R6";
        if (o == 25)            return "R8";
        if (o >= 21 && o <= 26) return "R7";
        if (o >= 27 && o <= 29) return "R9";
        return "R10";
    endfunction

    task automatic m_step(int o, logic [7:0] l);
        logic [7:0] ot, on, orr, v;
        ot = mt; on = mn; orr = mr;
        case (o)
            1, 2, 3, 4, 5: begin mt = exp_val(o, ot, on); d_pop(v); mn = v; end
            6, 7: begin d_push(on); mn = ot; mt = exp_val(o, ot, on); end
            8, 9, 10, 11, 12, 13, 14, 15, 16, 17, 18, 19, 20:
                mt = exp_val(o, ot, on);
            21: begin mt = on; d_pop(v); mn = v; end
            22: begin d_push(on); mn = ot; end
            23: begin d_pop(v); mn = v; end
            24: begin d_push(on); mn = ot; mt = on; end
            25: begin d_push(on); mn = ot; mt = l; end
            26: begin mt = on; mn = ot; end
            27: begin r_push(orr); mr = ot; mt = on; d_pop(v); mn = v; end
            28: begin d_push(on); mn = ot; mt = orr; r_pop(v); mr = v; end
            29: begin d_push(on); mn = ot; mt = orr; end
            default: ;
        endcase
    endtask

    task automatic compare_all(string req);
        chk(req, "T", tos, mt);
        chk(req, "N", nos, mn);
        chk(req, "R", rtop, mr);
        chk(req, "ds_fill", ds_fill, dcnt);
        chk(req, "rs_fill", rs_fill, rcnt);
        chk("R11", "ds_ovf", ds_ovf, dovf);
        chk("R11", "rs_ovf", rs_ovf, rovf);
        chk("R12", "ds_unf", ds_unf, dunf);
        chk("R12", "rs_unf", rs_unf, runf);
    endtask

    // Apply one op; outputs settle after the edge, sampled 1 ns later.
    task automatic do_op(int o, logic [7:0] l);
        op = 6'(o);
        lit = l;
        @(posedge clk);
        #1;
        m_step(o, l);
        compare_all(req_of(o));
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op = 6'd0;
        repeat (2) @(posedge clk);
        #1;
        rst_n = 1'b1;
        m_reset();
        compare_all("R1");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();

        // R3 carry corner: 0xFF + 0x01 carries
        do_op(25, 8'hFF);
        do_op(25, 8'h01);
        do_op(6, 8'h00);
        chk("R3", "carry value", tos, 8'h01);
        // R3 borrow corner: 0x01 - 0x02 borrows
        do_op(25, 8'h02);
        do_op(7, 8'h00);
        // R6 flag corners
        do_op(25, 8'h00); do_op(17, 8'h00);
        chk("R6", "zero flag", tos, 8'hFF);
        do_op(19, 8'h00); do_op(20, 8'h00); do_op(18, 8'h00);
        // R5 shift corners on 0x81
        for (int s = 10; s <= 16; s++) begin
            do_op(25, 8'h81);
            do_op(s, 8'h5A);
        end
        // R11 overflow: fill past data and return depth
        for (int i = 0; i < DSD + 3; i++) do_op(25, 8'(i * 7 + 1));
        chk("R11", "ds_ovf directed", ds_ovf, 1);
        for (int i = 0; i < RSD + 2; i++) do_op(27, 8'h00);
        // R12 underflow: drain both stacks beyond empty
        for (int i = 0; i < RSD + 3; i++) do_op(28, 8'h00);
        for (int i = 0; i < DSD + 6; i++) do_op(21, 8'h00);
        chk("R12", "ds_unf directed", ds_unf, 1);
        // R10 unused codes and nop hold state
        do_op(0, 8'hAA); do_op(30, 8'h11); do_op(63, 8'h22);

        // R1 reset clears sticky flags
        do_reset();

        // Random mix over all defined codes plus 30, 31
        for (int i = 0; i < 3000; i++) begin
            do_op(int'($urandom % 32), 8'($urandom));
        end

        do_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule